// File: doc/BRIEF.md
# Accumulator Pointer Auto-Modulo Unit

This block keeps a 4-bit pointer that chooses which of sixteen working accumulators the datapath uses. It also keeps a small control register. That register can move the pointer forward or backward by one after every completed arithmetic or logical operation. The move wraps inside a power-of-two window made of the pointer's low bits, which lets software cycle through 2, 4, 8 or 16 accumulators without rewriting the pointer.

Software reaches both registers through a single write port. A select input picks the pointer or the control register, and both registers can be read back at all times. The execution unit raises a one-cycle strobe when an operation completes. The block resolves every collision between an explicit write, a clear request and an automatic step by a fixed priority. Accumulator storage, instruction decode and the ALU sit outside this block.

Top module: `acc_ptr_unit`

## Requirements
- R1: After reset the pointer output is 0, pointer read-back is 00h and control read-back is 00h.
- R2: Control read-back holds the direction in bit 6 and the modulus code in bits 2:0. Bits 7 and 5:3 always read 0, even after a write of FFh. Pointer read-back carries the pointer in bits 3:0, and bits 7:4 read 0.
- R3: A control write (`wr_sel`=1) with bit 7 set forces the pointer to 0 on the next edge. This holds even when `op_done` is high in the same cycle with stepping enabled. The same write still stores its direction and modulus fields.
- R4: With modulus code 000, `op_done` leaves the pointer unchanged for either direction.
- R5: With modulus code k from 1 to 4, each `op_done` cycle changes the pointer on the next edge. The low k bits move by +1 (direction 0) or −1 (direction 1), modulo 2^k.
- R6: During a windowed step, pointer bits above the window keep their value.
- R7: Modulus codes 101, 110 and 111 step exactly like code 100 (modulo 16).
- R8: A pointer write (`wr_sel`=0) with `op_done` low loads `wr_data[3:0]` on the next edge. Bits 7:4 of the data are ignored.
- R9: When a pointer write and `op_done` fall in the same cycle and the modulus code is nonzero, the pointer takes the step of its current value and the written value is discarded. With code 000 the written value loads.
- R10: A step uses the control setting held before the edge. A control write without clear that coincides with `op_done` takes effect from the following operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears both registers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 pointer, 1 control |
| wr_data | input | 8 | Write data |
| op_done | input | 1 | One-cycle strobe: an arithmetic or logical operation completed |
| acc_sel | output | 4 | Current accumulator pointer |
| ptr_rdata | output | 8 | Pointer read-back, zero-extended |
| ctrl_rdata | output | 8 | Control read-back, reserved and clear bits as 0 |

## Verification
The bench builds the block with its default 4-bit pointer and 3-bit modulus code. At that size the bench can sweep every combination of the eight modulus codes, both directions and all sixteen start values. It does this once for a plain step and once for a step that collides with a pointer write, so every window boundary and every wrap in both directions is checked against an arithmetic model. The clear-override case is repeated from every start value, and the reserved-bit read-back and the deferred effect of a control write are checked directly.

// File: rtl/acc_ptr_pkg.sv
package acc_ptr_pkg;
    localparam int AP_PTR_W  = 4;
    localparam int AP_MODE_W = 3;
    localparam int AP_DATA_W = 8;
    localparam int AP_CLR_BIT = 7;
    localparam int AP_DIR_BIT = 6;

    typedef enum logic {
        SEL_PTR  = 1'b0,
        SEL_CTRL = 1'b1
    } ap_sel_e;
endpackage

// File: rtl/acc_ptr_stepper.sv
// Combinational windowed step: one candidate per window width, selected by mode.
module acc_ptr_stepper #(
    parameter int PTR_W  = 4,
    parameter int MODE_W = 3
) (
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              dir_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              step_en_o
);
    localparam int NWIN = PTR_W;
    localparam int IDXW = $clog2(NWIN + 1);

    logic [PTR_W-1:0] moved;
    logic [PTR_W-1:0] cand [NWIN+1];
    logic [IDXW-1:0]  win_idx;

    assign moved   = dir_i ? (ptr_i - 1'b1) : (ptr_i + 1'b1);
    assign cand[0] = ptr_i;

    generate
        for (genvar w = 1; w <= NWIN; w++) begin : g_win
            localparam logic [PTR_W-1:0] MASK = PTR_W'((1 << w) - 1);
            assign cand[w] = (ptr_i & ~MASK) | (moved & MASK);
        end
    endgenerate

    always_comb begin
        if (int'(mode_i) > NWIN) begin
            win_idx = IDXW'(NWIN);
        end else begin
            win_idx = IDXW'(mode_i);
        end
    end

    assign ptr_o     = cand[win_idx];
    assign step_en_o = (mode_i != '0);
endmodule

// File: rtl/acc_ptr_ctrl.sv
// Control register: direction and modulus code, plus a self-clearing clear request.
module acc_ptr_ctrl #(
    parameter int DATA_W  = 8,
    parameter int MODE_W  = 3,
    parameter int CLR_BIT = 7,
    parameter int DIR_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              dir_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic              dir;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  unused_wbits;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.dir  = wdata_i[DIR_BIT];
            ctrl_d.mode = wdata_i[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mode_o = ctrl_q.mode;
    assign dir_o  = ctrl_q.dir;
    assign clr_o  = wr_i & wdata_i[CLR_BIT];
    assign unused_wbits = ^wdata_i;

    always_comb begin
        rdata_o                = '0;
        rdata_o[DIR_BIT]       = ctrl_q.dir;
        rdata_o[MODE_W-1:0]    = ctrl_q.mode;
    end
endmodule

// File: rtl/acc_ptr_unit.sv
module acc_ptr_unit
    import acc_ptr_pkg::*;
#(
    parameter int PTR_W   = AP_PTR_W,
    parameter int MODE_W  = AP_MODE_W,
    parameter int DATA_W  = AP_DATA_W,
    parameter int CLR_BIT = AP_CLR_BIT,
    parameter int DIR_BIT = AP_DIR_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    output logic [PTR_W-1:0]  acc_sel,
    output logic [DATA_W-1:0] ptr_rdata,
    output logic [DATA_W-1:0] ctrl_rdata
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t        state_d, state_q;
    logic              ptr_wr, ctrl_wr;
    logic [MODE_W-1:0] mode;
    logic              dir;
    logic              clr_req;
    logic [PTR_W-1:0]  stepped;
    logic              step_en;

    assign ptr_wr  = wr_en && (ap_sel_e'(wr_sel) == SEL_PTR);
    assign ctrl_wr = wr_en && (ap_sel_e'(wr_sel) == SEL_CTRL);

    acc_ptr_ctrl #(
        .DATA_W (DATA_W),
        .MODE_W (MODE_W),
        .CLR_BIT(CLR_BIT),
        .DIR_BIT(DIR_BIT)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ctrl_wr),
        .wdata_i(wr_data),
        .mode_o (mode),
        .dir_o  (dir),
        .clr_o  (clr_req),
        .rdata_o(ctrl_rdata)
    );

    acc_ptr_stepper #(
        .PTR_W (PTR_W),
        .MODE_W(MODE_W)
    ) u_step (
        .ptr_i    (state_q.ptr),
        .mode_i   (mode),
        .dir_i    (dir),
        .ptr_o    (stepped),
        .step_en_o(step_en)
    );

    // Priority: clear, then auto-step, then explicit pointer write.
    always_comb begin
        state_d = state_q;
        if (clr_req) begin
            state_d.ptr = '0;
        end else if (op_done && step_en) begin
            state_d.ptr = stepped;
        end else if (ptr_wr) begin
            state_d.ptr = wr_data[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_sel = state_q.ptr;

    always_comb begin
        ptr_rdata              = '0;
        ptr_rdata[PTR_W-1:0]   = state_q.ptr;
    end

    // R3: clear request beats everything in its cycle
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[CLR_BIT]) |=> (acc_sel == '0));

    // R4: code 000 never moves the pointer on its own
    a_r4_mode0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && mode == '0) |=> $stable(acc_sel));

    // R6: modulo-2 window toggles bit 0 and keeps the rest
    a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_done && mode == MODE_W'(1)) |=>
        ((acc_sel[PTR_W-1:1] == $past(acc_sel[PTR_W-1:1])) &&
         (acc_sel[0] != $past(acc_sel[0]))));

    // R7: full-width and reserved codes increment modulo 2^PTR_W
    a_r7_full_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && op_done && int'(mode) >= PTR_W && !dir) |=>
        (acc_sel == PTR_W'($past(acc_sel) + 1'b1)));

    // R8: plain pointer write loads the low data bits
    a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && !op_done) |=> (acc_sel == $past(wr_data[PTR_W-1:0])));

    // R9: enabled step wins over a coincident pointer write
    a_r9_step_over_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && op_done && int'(mode) >= PTR_W && dir) |=>
        (acc_sel == PTR_W'($past(acc_sel) - 1'b1)));
endmodule

// File: tb/acc_ptr_unit_test.sv
`timescale 1ns/1ps
module acc_ptr_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       op_done = 1'b0;
    logic [3:0] acc_sel;
    logic [7:0] ptr_rdata;
    logic [7:0] ctrl_rdata;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    acc_ptr_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .op_done   (op_done),
        .acc_sel   (acc_sel),
        .ptr_rdata (ptr_rdata),
        .ctrl_rdata(ctrl_rdata)
    );

    function automatic logic [3:0] model_step(input logic [3:0] p, input logic [2:0] m,
                                              input logic d);
        int         w;
        logic [3:0] mask;
        logic [3:0] nx;
        w = (m == 3'd0) ? 0 : ((m > 3'd4) ? 4 : int'(m));
        if (w == 0) return p;
        mask = 4'((1 << w) - 1);
        nx   = d ? (p - 4'd1) : (p + 4'd1);
        return (p & ~mask) | (nx & mask);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample shortly after the edge.
    task automatic cyc(input logic we, input logic sel, input logic [7:0] d, input logic op);
        wr_en   = we;
        wr_sel  = sel;
        wr_data = d;
        op_done = op;
        @(posedge clk);
        #2;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = 8'h00;
        op_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_p;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 acc_sel", {4'h0, acc_sel}, 8'h00);
        check("R1 ptr_rdata", ptr_rdata, 8'h00);
        check("R1 ctrl_rdata", ctrl_rdata, 8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        #2;

        // Sweep plain steps: R4 (code 0), R5/R6 (1..4), R7 (5..7); R8 on the load
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 16; p++) begin
                    cyc(1'b1, 1'b0, {4'hA, 4'(p)}, 1'b0);
                    check("R8 load ignores upper data", ptr_rdata, {4'h0, 4'(p)});
                    cyc(1'b1, 1'b1, {1'b0, 1'(d), 3'b000, 3'(m)}, 1'b0);
                    cyc(1'b0, 1'b0, 8'h00, 1'b1);
                    exp_p = model_step(4'(p), 3'(m), 1'(d));
                    if (m == 0)
                        check("R4 code0 hold", {4'h0, acc_sel}, {4'h0, exp_p});
                    else if (m < 4)
                        check("R5/R6 window step", {4'h0, acc_sel}, {4'h0, exp_p});
                    else if (m == 4)
                        check("R5 mod16 step", {4'h0, acc_sel}, {4'h0, exp_p});
                    else
                        check("R7 reserved code", {4'h0, acc_sel}, {4'h0, exp_p});
                end
            end
        end

        // R9: pointer write collides with op_done
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 16; p++) begin
                    cyc(1'b1, 1'b0, {4'h0, 4'(p)}, 1'b0);
                    cyc(1'b1, 1'b1, {1'b0, 1'(d), 3'b000, 3'(m)}, 1'b0);
                    cyc(1'b1, 1'b0, {4'h0, 4'(p) ^ 4'h9}, 1'b1);
                    exp_p = (m == 0) ? (4'(p) ^ 4'h9) : model_step(4'(p), 3'(m), 1'(d));
                    check("R9 step over write", {4'h0, acc_sel}, {4'h0, exp_p});
                end
            end
        end

        // R3: clear overrides an enabled step, fields still stored, clear bit reads 0
        for (int p = 0; p < 16; p++) begin
            cyc(1'b1, 1'b0, {4'h0, 4'(p)}, 1'b0);
            cyc(1'b1, 1'b1, 8'h04, 1'b0);
            cyc(1'b1, 1'b1, 8'hC2, 1'b1);
            check("R3 clear wins", {4'h0, acc_sel}, 8'h00);
            check("R3 fields stored", ctrl_rdata, 8'h42);
        end

        // R2: reserved and clear bits read 0
        cyc(1'b1, 1'b1, 8'hFF, 1'b0);
        check("R2 ctrl reserved zero", ctrl_rdata, 8'h47);
        cyc(1'b1, 1'b1, 8'h38, 1'b0);
        check("R2 ctrl only reserved set", ctrl_rdata, 8'h00);
        cyc(1'b1, 1'b0, 8'hFB, 1'b0);
        check("R2 ptr upper zero", ptr_rdata, 8'h0B);

        // R10: control write during op_done uses the old setting
        cyc(1'b1, 1'b0, 8'h05, 1'b0);
        cyc(1'b1, 1'b1, 8'h00, 1'b0);
        cyc(1'b1, 1'b1, 8'h04, 1'b1);
        check("R10 old code0 applies", {4'h0, acc_sel}, 8'h05);
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        check("R10 new code applies", {4'h0, acc_sel}, 8'h06);
        cyc(1'b1, 1'b1, 8'h41, 1'b1);
        check("R10 old inc applies", {4'h0, acc_sel}, 8'h07);
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        check("R10 new mod2 dec", {4'h0, acc_sel}, 8'h06);

        // R1 again: mid-run reset
        rst_n = 1'b0;
        #2;
        check("R1 reset ptr", ptr_rdata, 8'h00);
        check("R1 reset ctrl", ctrl_rdata, 8'h00);
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule